// File: doc/BRIEF.md
# 20-bit Single-Cycle RISC Core

This block is a small processor core with a 20-bit datapath and 20-bit instruction words. Every instruction is fetched, decoded, executed and retired in one clock cycle. The instructions come from an internal instruction store, and loads and stores use a separate internal data store. A sixteen-entry register file holds the operands. The instruction set has eight register-register operations (add, subtract, and, or, nor, signed set-less-than, logical shift left, logical shift right). It also has an immediate add, a word load and a word store, two conditional branches (equal and not-equal), an absolute jump and an explicit no-operation.

A testbench or loader fills the instruction store through a write port while reset is held. After reset is released, the core runs from address zero. Three combinational debug read ports show the program counter, any register and any data word, so that a program's effect can be observed without stopping the core.

The instruction word places a 3-bit major opcode in bits 19:17 and the first source register in bits 16:13. The second source register (which is also the load and immediate destination) sits in bits 12:9. The remaining bits depend on the format:
- Register-register: destination in bits 8:5, a reserved bit 4 that must be zero, and a 4-bit function code in bits 3:0.
- Immediate: a signed 9-bit value in bits 8:0.
- Jump: a 17-bit absolute target in bits 16:0.

Top module: `core20_top`

## Requirements
- R1: Every instruction retires in one clock. The major opcodes are 000 register-register, 001 branch-if-equal, 010 branch-if-not-equal, 011 store, 100 jump, 101 load and 110 immediate add. Any instruction that does not branch or jump advances the 17-bit PC by exactly 1 on the next edge.
- R2: Opcode 000 with function codes 0001 add, 0010 subtract, 0011 and, 0100 or and 0101 nor writes `rs op rt`, modulo 2^20, into rd.
- R3: Function code 0110 writes 1 into rd when rs is less than rt as signed 20-bit numbers, and 0 otherwise.
- R4: Function codes 0111 (shift left) and 1000 (shift right) shift rt by the amount in rs[4:0], filling with zeros. Any amount of 20 or more gives 0.
- R5: Opcode 110 writes rs plus the sign-extended imm[8:0] into rt.
- R6: The load and store address is the low 8 bits of rs plus sign-extended imm[8:0]. A store writes rt to that data word and writes no register. A load copies that data word into rt.
- R7: A branch is taken when rs equals rt (opcode 001) or when rs differs from rt (opcode 010). A taken branch sets the PC to PC+1 plus the sign-extended imm[8:0], word-addressed. No branch writes a register or a data word.
- R8: Opcode 100 loads the zero-extended target[16:0] into the PC. Instruction fetch uses the low 8 PC bits, and PC+1 wraps modulo 2^17.
- R9: Register 0 always reads as zero, and a write addressed to it has no effect.
- R10: Function code 0000 under opcode 000 is a no-operation. So are function codes 1001 to 1111, a set reserved bit 4 and opcode 111. None of them changes any register or data word; each only advances the PC.
- R11: A synchronous active-high reset clears the PC and all registers. Data words and the instruction store keep their contents, and no store takes effect while reset is high.
- R12: The instruction store is written only through the load port, one word per edge while the load enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Instruction store write enable |
| ld_addr | input | 8 | Instruction store write address |
| ld_data | input | 20 | Instruction word to write |
| dbg_pc | output | 17 | Current program counter |
| dbg_reg_sel | input | 4 | Register index for the debug read |
| dbg_reg_val | output | 20 | Value of the selected register |
| dbg_mem_addr | input | 8 | Data word address for the debug read |
| dbg_mem_val | output | 20 | Value of the selected data word |

## Verification
The bench builds the core with its default store sizes: 8 address bits for both the instruction store and the data store. With that size, a store whose computed address passes 255 wraps into a low data word the bench can read back. A jump to the top of the 17-bit PC range fetches from the last instruction word and then wraps the PC to zero. Both wrap cases are checked. The signed 9-bit immediate is also exercised at its limits, +255 and -256.

// File: rtl/core20_pkg.sv
package core20_pkg;
  localparam int XW   = 20;
  localparam int RW   = 4;
  localparam int NREG = 1 << RW;
  localparam int PCW  = 17;
  localparam int IMMW = 9;
  localparam int SHW  = 5;

  typedef enum logic [2:0] {
    OP_RR = 3'd0, OP_BEQ = 3'd1, OP_BNE = 3'd2, OP_SW = 3'd3,
    OP_JMP = 3'd4, OP_LW = 3'd5, OP_ADDI = 3'd6
  } major_e;

  typedef enum logic [3:0] {
    FN_NOP = 4'd0, FN_ADD = 4'd1, FN_SUB = 4'd2, FN_AND = 4'd3, FN_OR = 4'd4,
    FN_NOR = 4'd5, FN_SLT = 4'd6, FN_SLL = 4'd7, FN_SRL = 4'd8
  } funct_e;

  typedef enum logic [2:0] {
    AL_ADD, AL_SUB, AL_AND, AL_OR, AL_NOR, AL_SLT, AL_SLL, AL_SRL
  } alu_sel_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       src_is_imm;
    logic       wb_from_mem;
    logic       reg_we;
    logic       mem_re;
    logic       mem_we;
    logic       is_branch;
    logic       is_jump;
    logic [1:0] alu_class;
  } ctl_t;

  function automatic logic [XW-1:0] sext_imm(input logic [IMMW-1:0] v);
    return {{(XW-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic [PCW-1:0] sext_off(input logic [IMMW-1:0] v);
    return {{(PCW-IMMW){v[IMMW-1]}}, v};
  endfunction

  function automatic logic signed_lt(input logic [XW-1:0] a, input logic [XW-1:0] b);
    return $signed(a) < $signed(b);
  endfunction

  function automatic logic [XW-1:0] shl(input logic [XW-1:0] v, input logic [SHW-1:0] n);
    return (n >= SHW'(XW)) ? '0 : (v << n);
  endfunction

  function automatic logic [XW-1:0] shr(input logic [XW-1:0] v, input logic [SHW-1:0] n);
    return (n >= SHW'(XW)) ? '0 : (v >> n);
  endfunction
endpackage

// File: rtl/core20_ctrl.sv
module core20_ctrl
  import core20_pkg::*;
(
  input  logic [XW-1:0] instr,
  output ctl_t          ctl,
  output alu_sel_e      alu_sel,
  output logic          br_on_ne
);
  logic [2:0] opc;
  logic [3:0] fn;
  logic       resv;
  logic       fn_ok;

  assign opc  = instr[19:17];
  assign fn   = instr[3:0];
  assign resv = instr[4];
  assign fn_ok = !resv && (fn >= 4'(FN_ADD)) && (fn <= 4'(FN_SRL));

  // Main decode
  always_comb begin
    ctl      = '0;
    br_on_ne = 1'b0;
    case (opc)
      3'(OP_RR): if (fn_ok) begin
        ctl.dst_is_rd = 1'b1; ctl.reg_we = 1'b1; ctl.alu_class = 2'b10;
      end
      3'(OP_BEQ): begin ctl.is_branch = 1'b1; ctl.alu_class = 2'b00; end
      3'(OP_BNE): begin ctl.is_branch = 1'b1; ctl.alu_class = 2'b00; br_on_ne = 1'b1; end
      3'(OP_SW):  begin ctl.src_is_imm = 1'b1; ctl.mem_we = 1'b1; ctl.alu_class = 2'b01; end
      3'(OP_JMP): ctl.is_jump = 1'b1;
      3'(OP_LW):  begin
        ctl.src_is_imm = 1'b1; ctl.wb_from_mem = 1'b1; ctl.reg_we = 1'b1;
        ctl.mem_re = 1'b1; ctl.alu_class = 2'b01;
      end
      3'(OP_ADDI): begin ctl.src_is_imm = 1'b1; ctl.reg_we = 1'b1; ctl.alu_class = 2'b01; end
      default: ctl = '0;
    endcase
  end

  // Secondary ALU decode
  always_comb begin
    alu_sel = AL_ADD;
    case (ctl.alu_class)
      2'b00: alu_sel = AL_SUB;
      2'b01: alu_sel = AL_ADD;
      2'b10: case (fn)
        4'(FN_SUB): alu_sel = AL_SUB;
        4'(FN_AND): alu_sel = AL_AND;
        4'(FN_OR):  alu_sel = AL_OR;
        4'(FN_NOR): alu_sel = AL_NOR;
        4'(FN_SLT): alu_sel = AL_SLT;
        4'(FN_SLL): alu_sel = AL_SLL;
        4'(FN_SRL): alu_sel = AL_SRL;
        default:    alu_sel = AL_ADD;
      endcase
      default: alu_sel = AL_ADD;
    endcase
  end
endmodule

// File: rtl/core20_alu.sv
module core20_alu
  import core20_pkg::*;
(
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  alu_sel_e      sel,
  output logic [XW-1:0] y,
  output logic          zero
);
  always_comb begin
    case (sel)
      AL_ADD:  y = a + b;
      AL_SUB:  y = a - b;
      AL_AND:  y = a & b;
      AL_OR:   y = a | b;
      AL_NOR:  y = ~(a | b);
      AL_SLT:  y = {{(XW-1){1'b0}}, signed_lt(a, b)};
      AL_SLL:  y = shl(b, a[SHW-1:0]);
      AL_SRL:  y = shr(b, a[SHW-1:0]);
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/core20_regfile.sv
module core20_regfile
  import core20_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] ra,
  input  logic [RW-1:0] rb,
  input  logic [RW-1:0] rdbg,
  output logic [XW-1:0] va,
  output logic [XW-1:0] vb,
  output logic [XW-1:0] vdbg,
  input  logic          we,
  input  logic [RW-1:0] wa,
  input  logic [XW-1:0] wd
);
  logic [XW-1:0] regs [NREG];
  logic          wr_fire;

  assign wr_fire = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_fire) begin
      regs[wa] <= wd;
    end
  end

  assign va   = regs[ra];
  assign vb   = regs[rb];
  assign vdbg = regs[rdbg];

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wa == '0) |=> (regs[0] == '0));
endmodule

// File: rtl/core20_top.sv
module core20_top
  import core20_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [IMEM_AW-1:0] ld_addr,
  input  logic [XW-1:0]      ld_data,
  output logic [PCW-1:0]     dbg_pc,
  input  logic [RW-1:0]      dbg_reg_sel,
  output logic [XW-1:0]      dbg_reg_val,
  input  logic [DMEM_AW-1:0] dbg_mem_addr,
  output logic [XW-1:0]      dbg_mem_val
);
  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  logic [XW-1:0]  imem [IDEPTH];
  logic [XW-1:0]  dmem [DDEPTH];
  logic [PCW-1:0] pc, pc_inc, pc_br, pc_nxt;
  logic [XW-1:0]  instr;
  ctl_t           ctl;
  alu_sel_e       alu_sel;
  logic           br_on_ne;
  logic [RW-1:0]  f_rs, f_rt, f_rd, wb_addr;
  logic [IMMW-1:0] f_imm;
  logic [PCW-1:0] f_tgt;
  logic [XW-1:0]  rs_v, rt_v, alu_b, alu_y, ld_v, wb_v;
  logic           alu_zero, take_br, rf_we, st_fire;
  logic [DMEM_AW-1:0] d_addr;

  // Instruction store: written only through the load port
  always_ff @(posedge clk) begin
    if (ld_en) imem[ld_addr] <= ld_data;
  end

  assign instr = imem[pc[IMEM_AW-1:0]];
  assign f_rs  = instr[16:13];
  assign f_rt  = instr[12:9];
  assign f_rd  = instr[8:5];
  assign f_imm = instr[IMMW-1:0];
  assign f_tgt = instr[PCW-1:0];

  core20_ctrl u_ctrl (.instr(instr), .ctl(ctl), .alu_sel(alu_sel), .br_on_ne(br_on_ne));

  assign wb_addr = ctl.dst_is_rd ? f_rd : f_rt;
  assign rf_we   = ctl.reg_we;

  core20_regfile u_rf (
    .clk(clk), .rst(rst),
    .ra(f_rs), .rb(f_rt), .rdbg(dbg_reg_sel),
    .va(rs_v), .vb(rt_v), .vdbg(dbg_reg_val),
    .we(rf_we), .wa(wb_addr), .wd(wb_v)
  );

  assign alu_b = ctl.src_is_imm ? sext_imm(f_imm) : rt_v;

  core20_alu u_alu (.a(rs_v), .b(alu_b), .sel(alu_sel), .y(alu_y), .zero(alu_zero));

  // Data store
  assign d_addr  = alu_y[DMEM_AW-1:0];
  assign st_fire = ctl.mem_we && !rst;
  assign ld_v    = ctl.mem_re ? dmem[d_addr] : '0;
  assign wb_v    = ctl.wb_from_mem ? ld_v : alu_y;

  always_ff @(posedge clk) begin
    if (st_fire) dmem[d_addr] <= rt_v;
  end

  assign dbg_mem_val = dmem[dbg_mem_addr];

  // Next PC
  assign take_br = ctl.is_branch && (alu_zero ^ br_on_ne);
  assign pc_inc  = pc + 1'b1;
  assign pc_br   = pc_inc + sext_off(f_imm);
  always_comb begin
    if (ctl.is_jump)   pc_nxt = f_tgt;
    else if (take_br)  pc_nxt = pc_br;
    else               pc_nxt = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  assign dbg_pc = pc;

  // R11
  pc_reset_chk: assert property (@(posedge clk) rst |=> (pc == '0));
  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl.is_jump && !take_br) |=> (pc == $past(pc) + 1'b1));
  // R8
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.is_jump |=> (pc == $past(f_tgt)));
  // R7
  br_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (take_br && !br_on_ne) |-> (rs_v == rt_v));
  // R7
  br_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.is_branch |-> (!rf_we && !st_fire));
  // R6
  store_noreg_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.mem_we |-> !rf_we);
  // R3
  slt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we && alu_sel == AL_SLT) |-> (wb_v[XW-1:1] == '0));
endmodule

// File: tb/core20_top_tb_top.sv
module core20_top_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic [19:0] ins;
    logic        is_mem;
    logic [7:0]  idx;
    logic [19:0] exp;
  } vec_t;

  function automatic logic [19:0] enc_r(input logic [3:0] fn, input logic [3:0] rd,
                                        input logic [3:0] rs, input logic [3:0] rt);
    return {3'b000, rs, rt, rd, 1'b0, fn};
  endfunction
  function automatic logic [19:0] enc_i(input logic [2:0] op, input logic [3:0] rt,
                                        input logic [3:0] rs, input int imm);
    logic [8:0] v;
    v = imm[8:0];
    return {op, rs, rt, v};
  endfunction
  function automatic logic [19:0] enc_j(input logic [16:0] t);
    return {3'b100, t};
  endfunction

  localparam vec_t TBL [NV] = '{
    '{enc_i(3'd6, 4'd1, 4'd0, 5),       1'b0, 8'd1,  20'h00005}, // R5
    '{enc_i(3'd6, 4'd2, 4'd0, -3),      1'b0, 8'd2,  20'hFFFFD}, // R5
    '{enc_r(4'd1, 4'd3, 4'd1, 4'd2),    1'b0, 8'd3,  20'h00002}, // R2 add
    '{enc_r(4'd2, 4'd4, 4'd1, 4'd2),    1'b0, 8'd4,  20'h00008}, // R2 sub
    '{enc_r(4'd3, 4'd5, 4'd1, 4'd2),    1'b0, 8'd5,  20'h00005}, // R2 and
    '{enc_r(4'd4, 4'd6, 4'd1, 4'd2),    1'b0, 8'd6,  20'hFFFFD}, // R2 or
    '{enc_r(4'd5, 4'd7, 4'd1, 4'd2),    1'b0, 8'd7,  20'h00002}, // R2 nor
    '{enc_r(4'd6, 4'd8, 4'd2, 4'd1),    1'b0, 8'd8,  20'h00001}, // R3
    '{enc_r(4'd6, 4'd9, 4'd1, 4'd2),    1'b0, 8'd9,  20'h00000}, // R3
    '{enc_r(4'd7, 4'd10, 4'd3, 4'd1),   1'b0, 8'd10, 20'h00014}, // R4 sll
    '{enc_r(4'd8, 4'd11, 4'd4, 4'd2),   1'b0, 8'd11, 20'h00FFF}, // R4 srl
    '{enc_i(3'd6, 4'd12, 4'd0, 255),    1'b0, 8'd12, 20'h000FF}, // R5
    '{enc_i(3'd6, 4'd13, 4'd0, -256),   1'b0, 8'd13, 20'hFFF00}, // R5
    '{enc_r(4'd7, 4'd14, 4'd12, 4'd1),  1'b0, 8'd14, 20'h00000}, // R4 amount 31
    '{enc_r(4'd1, 4'd0, 4'd1, 4'd1),    1'b0, 8'd0,  20'h00000}, // R9
    '{enc_i(3'd3, 4'd1, 4'd0, 9),       1'b1, 8'd9,  20'h00005}, // R6 store
    '{enc_i(3'd5, 4'd15, 4'd1, 4),      1'b0, 8'd15, 20'h00005}, // R6 load
    '{enc_r(4'd8, 4'd9, 4'd1, 4'd13),   1'b0, 8'd9,  20'h07FF8}, // R4
    '{enc_r(4'd0, 4'd0, 4'd0, 4'd0),    1'b0, 8'd15, 20'h00005}, // R10 nop
    '{enc_i(3'd3, 4'd6, 4'd13, 16),     1'b1, 8'h10, 20'hFFFFD}, // R6 wrap
    '{{3'b111, 4'd1, 4'd1, 4'd15, 5'd1}, 1'b0, 8'd15, 20'h00005}, // R10 op 111
    '{enc_r(4'd9, 4'd15, 4'd1, 4'd1),   1'b0, 8'd15, 20'h00005}, // R10 fn 1001
    '{{3'b000, 4'd1, 4'd1, 4'd15, 5'b10001}, 1'b0, 8'd15, 20'h00005}, // R10 bit4
    '{enc_i(3'd6, 4'd15, 4'd15, -1),    1'b0, 8'd15, 20'h00004}  // R5
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [19:0] ld_data = '0;
  logic [16:0] dbg_pc;
  logic [3:0]  dbg_reg_sel = '0;
  logic [19:0] dbg_reg_val;
  logic [7:0]  dbg_mem_addr = '0;
  logic [19:0] dbg_mem_val;
  int checks = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  core20_top dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_pc(dbg_pc), .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_val(dbg_mem_val)
  );

  task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd_reg(input logic [3:0] r, output logic [19:0] v);
    dbg_reg_sel = r; #1; v = dbg_reg_val;
  endtask
  task automatic rd_mem(input logic [7:0] a, output logic [19:0] v);
    dbg_mem_addr = a; #1; v = dbg_mem_val;
  endtask
  task automatic put(input logic [7:0] a, input logic [19:0] w);
    @(negedge clk); ld_en = 1'b1; ld_addr = a; ld_data = w;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] v;
    logic [16:0] bseq [10];
    // R12: fill the whole instruction store with no-ops, then the table program
    rst = 1'b1;
    for (int a = 0; a < 256; a++) put(8'(a), 20'h0);
    for (int i = 0; i < NV; i++) put(8'(i), TBL[i].ins);
    @(negedge clk); ld_en = 1'b0;
    // R11 reset state
    chk("R11 pc after reset", 20'(dbg_pc), 20'h0);
    rd_reg(4'd1, v); chk("R11 reg after reset", v, 20'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      // R1 straight-line PC
      chk("R1 pc", 20'(dbg_pc), 20'(i));
      @(negedge clk);
      if (TBL[i].is_mem) begin rd_mem(TBL[i].idx, v); chk("R6 table mem", v, TBL[i].exp); end
      else begin rd_reg(TBL[i].idx[3:0], v); chk($sformatf("table row %0d", i), v, TBL[i].exp); end
    end
    rd_reg(4'd1, v); chk("R2 r1 untouched by other ops", v, 20'h00005);

    // R11 reset mid-run: regs and PC cleared, data words kept
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R11 pc cleared", 20'(dbg_pc), 20'h0);
    rd_reg(4'd6, v); chk("R11 r6 cleared", v, 20'h0);
    rd_mem(8'd9, v); chk("R11 data kept", v, 20'h00005);

    // R7 / R8 branch and jump program (loaded under reset)
    put(8'd0,  enc_i(3'd6, 4'd1, 4'd0, 7));
    put(8'd1,  enc_i(3'd6, 4'd2, 4'd0, 7));
    put(8'd2,  enc_i(3'd1, 4'd2, 4'd1, 2));   // beq taken -> 5
    put(8'd3,  enc_i(3'd6, 4'd3, 4'd0, 1));
    put(8'd4,  enc_i(3'd6, 4'd3, 4'd0, 2));
    put(8'd5,  enc_i(3'd2, 4'd2, 4'd1, 3));   // bne not taken
    put(8'd6,  enc_i(3'd1, 4'd0, 4'd1, 5));   // beq not taken
    put(8'd7,  enc_i(3'd2, 4'd0, 4'd1, 2));   // bne taken -> 10
    put(8'd8,  enc_i(3'd6, 4'd3, 4'd0, 3));
    put(8'd9,  enc_i(3'd6, 4'd3, 4'd0, 3));
    put(8'd10, enc_j(17'd14));
    put(8'd11, enc_i(3'd6, 4'd3, 4'd0, 4));
    put(8'd14, enc_j(17'h1FFFF));
    put(8'd255, 20'h0);
    @(negedge clk); ld_en = 1'b0; rst = 1'b0;
    bseq = '{17'd0, 17'd1, 17'd2, 17'd5, 17'd6, 17'd7, 17'd10, 17'd14, 17'h1FFFF, 17'd0};
    for (int k = 0; k < 10; k++) begin
      // R7 R8 PC trace
      chk($sformatf("R7/R8 pc step %0d", k), 20'(dbg_pc), 20'(bseq[k]));
      @(negedge clk);
    end
    rd_reg(4'd3, v); chk("R7 skipped writes", v, 20'h0);
    rd_reg(4'd2, v); chk("R7 branch wrote no reg", v, 20'h00007);
    rd_mem(8'h10, v); chk("R7 branch wrote no data", v, 20'hFFFFD);
    rd_reg(4'd0, v); chk("R9 r0 reads zero", v, 20'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule